// File: doc/BRIEF.md
# Vertical Line Count Meter

This block measures the vertical timing of a video raster by counting horizontal sync pulses. The count is taken relative to the leading edge of an already polarity-corrected vertical sync. The block reports four values per frame: how many lines the vertical sync lasts, how many lines the whole frame spans, the index of the first line that carried active video, and the index of the last such line. Its inputs are single-cycle strobes for the horizontal sync, the vertical sync leading edge and the vertical sync trailing edge, plus a flag that is high whenever video is detected.

Measurements gather in a set of working registers during a frame. At each vertical leading edge they are copied into read registers, and the working state restarts. The read words therefore stay stable for a full frame, so a controller can read them out at any time. Each read word places the line count in its upper bits and fills the low bits with zeros.

Top module: `vline_meter`

## Requirements
- R1: After reset, all four read words are zero.
- R2: One cycle after a vertical leading-edge strobe, the period word holds the number of horizontal sync strobes seen since the previous leading-edge strobe.
- R3: The width word holds the number of horizontal sync strobes between the leading-edge strobe and the trailing-edge strobe of the previous frame. If no trailing edge occurred in that frame, the width word is zero.
- R4: Lines are numbered from 0 at the leading edge, and each horizontal sync strobe ends a line. A line is active if video_seen is high in any cycle of that line, including the cycle of its ending strobe. The first-line word holds the index of the earliest active line of the previous frame.
- R5: The last-line word holds the index of the latest active line of the previous frame. Inactive lines between active ones do not affect it.
- R6: In a frame with no active line, both the first-line word and the last-line word read zero.
- R7: The line count saturates at 4095 and does not wrap, so a frame longer than 4095 lines reports a period of 4095.
- R8: The read words change only in the cycle after a leading-edge strobe. Between leading edges they hold their values.
- R9: Each 16-bit read word carries the 12-bit count in bits 15:4, and bits 3:0 are always zero.
- R10: A horizontal sync strobe in the same cycle as a leading-edge strobe is not counted. Video seen in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_stb | input | 1 | One-cycle strobe per horizontal sync pulse |
| vs_lead_stb | input | 1 | One-cycle strobe at the vertical sync leading edge |
| vs_trail_stb | input | 1 | One-cycle strobe at the vertical sync trailing edge |
| video_seen | input | 1 | High while active video is detected |
| rd_width | output | 16 | Vertical sync width in lines, left-aligned |
| rd_period | output | 16 | Frame period in lines, left-aligned |
| rd_first | output | 16 | First active line index, left-aligned |
| rd_last | output | 16 | Last active line index, left-aligned |

## Verification
Frames are driven with these patterns:
- A contiguous block of active lines, and a different geometry afterwards. These show that width, period, first line and last line are each taken from their own event.
- A frame with only two isolated active lines separated by blank ones. This distinguishes "last active line" from "last line before a blank".
- A frame with no video. This confirms that the first-line and last-line words fall back to zero.
- An overlong frame, which exposes wrapping as opposed to saturation.
- A frame whose start coincides with a horizontal strobe, which checks the rule that the leading edge takes priority.

In a further test the read words are sampled in the middle of a frame to prove they hold between leading edges.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
   localparam int unsigned VLM_NCH   = 4;
   localparam int unsigned CH_WIDTH  = 0;
   localparam int unsigned CH_PERIOD = 1;
   localparam int unsigned CH_FIRST  = 2;
   localparam int unsigned CH_LAST   = 3;
endpackage

// File: rtl/vlm_line_counter.sv
module vlm_line_counter #(
   parameter int unsigned CNT_W    = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_nxt;
   end

   assign count = cnt_q;
endmodule

// File: rtl/vlm_active_tracker.sv
module vlm_active_tracker #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             line_end,
   input  logic             video_seen,
   input  logic [CNT_W-1:0] line_idx,
   output logic [CNT_W-1:0] first_line,
   output logic [CNT_W-1:0] last_line
);
   logic             pend_q;
   logic             found_q;
   logic [CNT_W-1:0] first_q;
   logic [CNT_W-1:0] last_q;
   logic             hit;

   assign hit = line_end & ~restart & (pend_q | video_seen);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) pend_q <= 1'b0;
      else if (line_end)     pend_q <= 1'b0;
      else if (video_seen)   pend_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         found_q <= 1'b0;
         first_q <= '0;
         last_q  <= '0;
      end else if (hit) begin
         last_q <= line_idx;
         if (!found_q) begin
            found_q <= 1'b1;
            first_q <= line_idx;
         end
      end
   end

   assign first_line = first_q;
   assign last_line  = last_q;
endmodule

// File: rtl/vlm_result_bank.sv
module vlm_result_bank #(
   parameter int unsigned NCH    = 4,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned WORD_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [NCH-1:0][CNT_W-1:0]   live_vals,
   output logic [NCH-1:0][WORD_W-1:0]  words
);
   localparam int unsigned PAD_W = WORD_W - CNT_W;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [CNT_W-1:0] hold_q;

      always_ff @(posedge clk) begin
         if (!rst_n)    hold_q <= '0;
         else if (load) hold_q <= live_vals[ch];
      end

      if (PAD_W == 0) begin : g_nopad
         assign words[ch] = hold_q;
      end else begin : g_pad
         assign words[ch] = {hold_q, {PAD_W{1'b0}}};
      end
   end
endmodule

// File: rtl/vline_meter.sv
module vline_meter #(
   parameter int unsigned CNT_W    = 12,
   parameter int unsigned WORD_W   = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_stb,
   input  logic              vs_lead_stb,
   input  logic              vs_trail_stb,
   input  logic              video_seen,
   output logic [WORD_W-1:0] rd_width,
   output logic [WORD_W-1:0] rd_period,
   output logic [WORD_W-1:0] rd_first,
   output logic [WORD_W-1:0] rd_last
);
   import vlm_pkg::*;

   generate
      if (CNT_W < 2)      begin : g_bad_cnt  $error("CNT_W must be at least 2");      end
      if (WORD_W < CNT_W) begin : g_bad_word $error("WORD_W must not be below CNT_W"); end
   endgenerate

   logic [CNT_W-1:0] line_cnt;
   logic [CNT_W-1:0] width_q;
   logic [CNT_W-1:0] first_w;
   logic [CNT_W-1:0] last_w;
   logic             line_step;
   logic [VLM_NCH-1:0][CNT_W-1:0]  live;
   logic [VLM_NCH-1:0][WORD_W-1:0] words;

   assign line_step = hs_stb & ~vs_lead_stb;

   vlm_line_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (vs_lead_stb),
      .step    (line_step),
      .count   (line_cnt)
   );

   vlm_active_tracker #(.CNT_W(CNT_W)) u_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (vs_lead_stb),
      .line_end   (hs_stb),
      .video_seen (video_seen),
      .line_idx   (line_cnt),
      .first_line (first_w),
      .last_line  (last_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || vs_lead_stb) width_q <= '0;
      else if (vs_trail_stb)     width_q <= line_cnt;
   end

   always_comb begin
      live[CH_WIDTH]  = width_q;
      live[CH_PERIOD] = line_cnt;
      live[CH_FIRST]  = first_w;
      live[CH_LAST]   = last_w;
   end

   vlm_result_bank #(.NCH(VLM_NCH), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (vs_lead_stb),
      .live_vals (live),
      .words     (words)
   );

   assign rd_width  = words[CH_WIDTH];
   assign rd_period = words[CH_PERIOD];
   assign rd_first  = words[CH_FIRST];
   assign rd_last   = words[CH_LAST];
endmodule

// File: rtl/vlm_checker.sv
module vlm_checker #(
   parameter int unsigned CNT_W    = 12,
   parameter int unsigned WORD_W   = 16,
   parameter bit          SATURATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hs_stb,
   input logic              vs_lead_stb,
   input logic [CNT_W-1:0]  line_cnt,
   input logic [WORD_W-1:0] rd_width,
   input logic [WORD_W-1:0] rd_period,
   input logic [WORD_W-1:0] rd_first,
   input logic [WORD_W-1:0] rd_last
);
   localparam int unsigned      PAD_W   = WORD_W - CNT_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   a_r8_hold_between_leads: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_lead_stb |=> ($stable(rd_width) && $stable(rd_period) && $stable(rd_first) && $stable(rd_last)));

   a_r10_lead_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      vs_lead_stb |=> (line_cnt == '0));

   a_r2_period_from_count: assert property (@(posedge clk) disable iff (!rst_n)
      vs_lead_stb |=> (rd_period[WORD_W-1:PAD_W] == $past(line_cnt)));

   a_r5_first_not_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      rd_first <= rd_last);

   a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (PAD_W == 0) || ((rd_width | rd_period | rd_first | rd_last) >> PAD_W) << PAD_W
         == (rd_width | rd_period | rd_first | rd_last));

   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && hs_stb && !vs_lead_stb && line_cnt == CNT_MAX) |=> (line_cnt == CNT_MAX));
endmodule

bind vline_meter vlm_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W), .SATURATE(SATURATE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hs_stb      (hs_stb),
   .vs_lead_stb (vs_lead_stb),
   .line_cnt    (line_cnt),
   .rd_width    (rd_width),
   .rd_period   (rd_period),
   .rd_first    (rd_first),
   .rd_last     (rd_last)
);

// File: tb/vline_meter_tb.sv
module vline_meter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_stb = 1'b0, vs_lead_stb = 1'b0, vs_trail_stb = 1'b0, video_seen = 1'b0;
   logic [15:0] rd_width, rd_period, rd_first, rd_last;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vline_meter u_dut (
      .clk(clk), .rst_n(rst_n), .hs_stb(hs_stb), .vs_lead_stb(vs_lead_stb),
      .vs_trail_stb(vs_trail_stb), .video_seen(video_seen),
      .rd_width(rd_width), .rd_period(rd_period), .rd_first(rd_first), .rd_last(rd_last)
   );

   function automatic logic [15:0] enc(int v);
      return 16'((v & 12'hFFF) << 4);
   endfunction

   task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req, int w, int p, int f, int l);
      chk(req, "width",  rd_width,  enc(w));
      chk(req, "period", rd_period, enc(p));
      chk(req, "first",  rd_first,  enc(f));
      chk(req, "last",   rd_last,   enc(l));
   endtask

   // leading edge; outputs valid at the following negedge
   task automatic lead(bit with_hs);
      @(negedge clk);
      vs_lead_stb = 1'b1; hs_stb = with_hs; video_seen = with_hs;
      @(negedge clk);
      vs_lead_stb = 1'b0; hs_stb = 1'b0; video_seen = 1'b0;
   endtask

   // n lines; line i is active when mask[i]; trailing edge after w strobes
   task automatic lines(int w, int n, logic [63:0] mask);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         video_seen = (i < 64) ? mask[i] : 1'b0;
         @(negedge clk);
         video_seen = 1'b0; hs_stb = 1'b1;
         @(negedge clk);
         hs_stb = 1'b0;
         vs_trail_stb = (i + 1 == w);
         @(negedge clk);
         vs_trail_stb = 1'b0;
      end
   endtask

   task automatic t_reset;
      check_all("R1", 0, 0, 0, 0);
   endtask

   task automatic t_basic;
      lead(0);
      lines(3, 20, 64'h0000_0000_0000_3FC0); // lines 6..13
      lead(0);
      check_all("R2/R3/R4/R5", 3, 20, 6, 13);
      lines(5, 30, 64'h0000_0000_0FFF_FC00); // lines 10..27
      lead(0);
      check_all("R2/R3/R4/R5 second geometry", 5, 30, 10, 27);
   endtask

   task automatic t_gap;
      lines(2, 12, 64'h0000_0000_0000_0208); // lines 3 and 9
      lead(0);
      chk("R4", "first isolated", rd_first, enc(3));
      chk("R5", "last after gap", rd_last, enc(9));
   endtask

   task automatic t_novideo;
      lines(4, 15, 64'h0);
      lead(0);
      chk("R6", "first no video", rd_first, enc(0));
      chk("R6", "last no video", rd_last, enc(0));
      chk("R2", "period no video", rd_period, enc(15));
   endtask

   task automatic t_hold;
      lines(2, 8, 64'h0000_0000_0000_00F0);
      lead(0);
      check_all("R8 frame A", 2, 8, 4, 7);
      lines(6, 10, 64'h0000_0000_0000_0006);
      check_all("R8 mid-frame hold", 2, 8, 4, 7);
      lines(0, 5, 64'h0);
      lead(0);
      check_all("R8 frame B", 6, 15, 1, 2);
   endtask

   task automatic t_notrail;
      lines(0, 9, 64'h1);
      lead(0);
      chk("R3", "width without trail", rd_width, enc(0));
   endtask

   task automatic t_saturate;
      lines(5, 4200, 64'h4);
      lead(0);
      chk("R7", "period saturates", rd_period, enc(4095));
      chk("R7", "width in long frame", rd_width, enc(5));
      chk("R9", "low nibble zero", rd_period & 16'h000F, 16'h0000);
   endtask

   task automatic t_coincide;
      lead(1);  // strobe and video with the edge are discarded
      lines(2, 7, 64'h0000_0000_0000_0010);
      lead(0);
      check_all("R10", 2, 7, 4, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_gap();
      t_novideo();
      t_hold();
      t_notrail();
      t_coincide();
      t_saturate();
      chk("R9", "low nibble zero all", (rd_width | rd_first | rd_last) & 16'h000F, 16'h0000);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule